// File: doc/BRIEF.md
# Configurable Processor Bus Interface

This block sits between an external microcontroller and a peripheral's internal register file. It turns chip select, strobes and address/data pins into single-cycle internal register read and write pulses, with an 8-bit register address and 16-bit register data. A strap input captured during reset picks the bus topology. In the generic topology a dedicated 8-bit address bus selects the register, and a 16-bit data bus is shared by processor accesses and DMA. In the split topology an 8-bit multiplexed address/data bus serves the processor, and the 16-bit data bus carries only DMA traffic.

Two live mode inputs refine the protocol. The strobe style is either a direction line with a data strobe, or separate read and write strobes. In the split topology, the address is taken either from an address-latch-enable pulse or from an address/data select line. With the select line, a write with the line low loads the address, and a later access with the line high moves data. The split topology carries 8 bits per access: register writes are zero-extended, and reads return the register's low byte. All control pins pass through two-stage synchronisers. A write takes effect when its strobe deasserts.

A separate pair of DMA strobes moves 16-bit words between the data bus and a stub DMA interface. In the generic topology a processor access that overlaps a DMA transfer wins. The overlapped DMA transfer is dropped, and a collision flag is raised that stays set until reset. Master operation of the DMA port is granted only in the split topology.

Top module: `cpu_bus_if`

## Requirements
- R1: `strap_generic` is captured only while `rst_n` is low (1 = generic topology, 0 = split topology); changing it after reset has no effect on decoding. Out of reset `data_oe`, `ad_oe`, `collision` and `dma_master` are 0, and no pulse is issued.
- R2: Generic topology, separate strobes (`strobe_sel` = 1): a write with `cs_n` and `wr_n` low gives exactly one `reg_wr` pulse after `wr_n` rises, with `reg_addr` = `ad_i` and `reg_wdata` = `data_i`.
- R3: With `strobe_sel` = 0, `ds_n` low with `rw` = 0 performs a write, and `ds_n` low with `rw` = 1 performs a read, with the same results as R2 and R4.
- R4: Generic topology read: a read gives exactly one `reg_rd` pulse with `reg_addr` = `ad_i`. While the strobe is held, `data_oe` = 1 and `data_o` = `reg_rdata`, and `ad_oe` stays 0.
- R5: With `cs_n` high, processor strobes produce no `reg_wr`, no `reg_rd` and no bus drive.
- R6: Split topology, `latch_sel` = 0: `addr_sel` high loads `reg_addr` from `ad_i`. A write yields `reg_wdata` = {8'h00, `ad_i`}. A read drives `ad_o` with the low byte of `reg_rdata` and `ad_oe` = 1, while `data_oe` stays 0.
- R7: Split topology, `latch_sel` = 1: a write with `addr_sel` = 0 loads the address and gives no `reg_wr`. A write with `addr_sel` = 1 writes {8'h00, `ad_i`} to that address. A read with `addr_sel` = 0 returns the latched address on `ad_o` with no `reg_rd`. A read with `addr_sel` = 1 returns the register's low byte.
- R8: A DMA write (`dma_wr_n` low then high) gives one `dma_wr` pulse with `dma_wdata` = `data_i`. A DMA read gives one `dma_rd` pulse and drives `data_o` = `dma_rdata` with `data_oe` = 1 while held.
- R9: `dma_master` = 1 only when `dma_master_req` = 1 in the split topology; it is 0 in the generic topology.
- R10: Generic topology: a DMA transfer that overlaps a chip-selected processor access issues no DMA pulse. The processor access still completes, and `collision` becomes 1 and stays 1 until reset.
- R11: Split topology: processor and DMA accesses may overlap; both complete and `collision` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; also the strap capture window |
| strap_generic | input | 1 | Topology strap: 1 generic, 0 split |
| strobe_sel | input | 1 | 1 separate read/write strobes, 0 direction plus data strobe |
| latch_sel | input | 1 | Split topology address method: 0 latch-enable pulse, 1 select line |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | Direction: 1 read, 0 write |
| addr_sel | input | 1 | Address latch enable or address/data select line |
| ad_i | input | 8 | Address bus (generic) or multiplexed bus input (split) |
| ad_o | output | 8 | Multiplexed bus read data |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| data_i | input | 16 | Data bus input |
| data_o | output | 16 | Data bus output |
| data_oe | output | 1 | Drive enable for `data_o` |
| dma_rd_n | input | 1 | DMA read strobe, active low |
| dma_wr_n | input | 1 | DMA write strobe, active low |
| dma_master_req | input | 1 | Request for master operation of the DMA port |
| dma_master | output | 1 | DMA port granted master operation |
| reg_addr | output | 8 | Register file address |
| reg_wr | output | 1 | Register write pulse |
| reg_wdata | output | 16 | Register write data |
| reg_rd | output | 1 | Register read pulse |
| reg_rdata | input | 16 | Register file read data for `reg_addr` |
| dma_wr | output | 1 | DMA write pulse |
| dma_wdata | output | 16 | DMA write word |
| dma_rd | output | 1 | DMA read pulse |
| dma_rdata | input | 16 | DMA read word |
| collision | output | 1 | Sticky generic-topology overlap flag |

## Verification
The assertions assume that the strap does not change during the last cycle of reset. They also assume that each strobe stays low for at least two clock cycles, that the address and data pins are stable while a strobe is low, and that the mode inputs change only while the bus is idle. The stimulus changes every pin on the falling clock edge and holds each strobe low for four or more cycles. It leaves several idle cycles between accesses and sets the mode inputs only between scenarios, so every synchroniser delay is covered before a result is sampled.

// File: rtl/cpu_bus_pkg.sv
`timescale 1ns/1ps
// Shared types for the configurable processor bus interface.
// Assumes: control pins are grouped into one vector before synchronising.
package cpu_bus_pkg;

    // Decoding topology chosen by the strap and the address-method input
    typedef enum logic [1:0] {
        MODE_GENERIC   = 2'd0,
        MODE_SPLIT_ALE = 2'd1,
        MODE_SPLIT_SEL = 2'd2
    } bus_mode_e;

    // Control pins as one packed group, raw or synchronised
    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic wr_n;
        logic ds_n;
        logic rw;
        logic sel;
        logic drd_n;
        logic dwr_n;
    } ctl_t;

    // Idle level of each control pin, used as the synchroniser reset value
    localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, ds_n: 1'b1,
                                  rw: 1'b1, sel: 1'b0, drd_n: 1'b1, dwr_n: 1'b1};

endpackage

// File: rtl/cpu_bus_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a vector of asynchronous control pins.
// Assumes: each bit is independent; bus-level skew is absorbed by the protocol.
module cpu_bus_sync #(
    parameter int             WIDTH   = 8,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // Shift the sampled value one stage further
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg[i] <= RST_VAL;
            end else if (i == 0) begin
                stg[i] <= d;
            end else begin
                stg[i] <= stg[(i > 0) ? i - 1 : 0];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cpu_bus_host_port.sv
`timescale 1ns/1ps
// Processor side decoder: turns synchronised chip select and strobes into
// register read/write pulses and drives read data back onto the right bus.
// Assumes: address and data pins are stable while a strobe is active; mode
// inputs change only while idle; DW > AW.
module cpu_bus_host_port
    import cpu_bus_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_mode_e     mode,
    input  logic          strobe_sel,
    input  ctl_t          ctl,
    input  logic [AW-1:0] ad_i,
    input  logic [DW-1:0] data_i,
    input  logic [DW-1:0] reg_rdata,
    output logic [AW-1:0] reg_addr,
    output logic          reg_wr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_rd,
    output logic          busy,
    output logic [AW-1:0] ad_o,
    output logic          ad_oe,
    output logic [DW-1:0] dbus_o,
    output logic          dbus_oe
);
    localparam int PAD_W = DW - AW;

    logic          rd_lvl, wr_lvl, rd_act, wr_act;
    logic          is_split, data_phase;
    logic          rd_q1, rd_q2, wr_q1;
    logic          phase_cap;
    logic          wr_commit, rd_start;
    logic [DW-1:0] wbuf, rbuf;
    logic [AW-1:0] addr_q;
    logic          reg_wr_q;
    logic [DW-1:0] reg_wdata_q;

    // Strobe style decode, qualified by chip select
    always_comb begin
        rd_lvl = strobe_sel ? ~ctl.rd_n : (~ctl.ds_n &  ctl.rw);
        wr_lvl = strobe_sel ? ~ctl.wr_n : (~ctl.ds_n & ~ctl.rw);
        rd_act = ~ctl.cs_n & rd_lvl & ~wr_lvl;
        wr_act = ~ctl.cs_n & wr_lvl & ~rd_lvl;
    end

    // Topology helpers: split flag and whether this access is a data phase
    always_comb begin
        is_split   = (mode != MODE_GENERIC);
        data_phase = (mode != MODE_SPLIT_SEL) | ctl.sel;
        wr_commit  = wr_q1 & ~wr_act;
        rd_start   = rd_q1 & ~rd_q2;
    end

    // Strobe history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q1 <= 1'b0;
            rd_q2 <= 1'b0;
            wr_q1 <= 1'b0;
        end else begin
            rd_q1 <= rd_act;
            rd_q2 <= rd_q1;
            wr_q1 <= wr_act;
        end
    end

    // Capture phase type and write data while the access is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_cap <= 1'b0;
            wbuf      <= '0;
        end else begin
            if (rd_act || wr_act) phase_cap <= data_phase;
            if (wr_act) wbuf <= is_split ? {{PAD_W{1'b0}}, ad_i} : data_i;
        end
    end

    // Address register, loaded per topology
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            case (mode)
                MODE_GENERIC:   if (rd_act || wr_act) addr_q <= ad_i;
                MODE_SPLIT_ALE: if (ctl.sel) addr_q <= ad_i;
                MODE_SPLIT_SEL: if (wr_commit && !phase_cap) addr_q <= wbuf[AW-1:0];
                default:        addr_q <= addr_q;
            endcase
        end
    end

    // Register write pulse and data on strobe deassertion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_wr_q    <= 1'b0;
            reg_wdata_q <= '0;
        end else begin
            reg_wr_q <= wr_commit & phase_cap;
            if (wr_commit && phase_cap) reg_wdata_q <= wbuf;
        end
    end

    // Hold the register read value for the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf <= '0;
        end else if (reg_rd) begin
            rbuf <= reg_rdata;
        end
    end

    // Read data routing onto the bus that the topology uses
    always_comb begin
        reg_rd    = rd_start & phase_cap;
        reg_addr  = addr_q;
        reg_wr    = reg_wr_q;
        reg_wdata = reg_wdata_q;
        busy      = rd_act | wr_act;
        dbus_o    = rbuf;
        dbus_oe   = ~is_split & rd_q2 & rd_act;
        ad_o      = phase_cap ? rbuf[AW-1:0] : addr_q;
        ad_oe     = is_split & rd_q2 & rd_act;
    end
endmodule

// File: rtl/cpu_bus_dma_port.sv
`timescale 1ns/1ps
// DMA side of the interface: dedicated strobes move words between the data
// bus and the DMA stub. In the generic topology a processor access wins any
// overlap; the DMA transfer is dropped and a sticky collision flag is raised.
// Assumes: DMA strobes are never both active at once.
module cpu_bus_dma_port #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          generic,
    input  logic          drd_n,
    input  logic          dwr_n,
    input  logic          host_busy,
    input  logic          master_req,
    input  logic [DW-1:0] data_i,
    input  logic [DW-1:0] dma_rdata,
    output logic          dma_wr,
    output logic [DW-1:0] dma_wdata,
    output logic          dma_rd,
    output logic [DW-1:0] dbus_o,
    output logic          dbus_oe,
    output logic          collision,
    output logic          dma_master
);
    logic          rd_a, wr_a, rd_q1, rd_q2, wr_q1;
    logic          overlap, start, spoil;
    logic [DW-1:0] wbuf, rbuf, wdata_q;
    logic          dma_wr_q, coll_q;

    // Activity, start and overlap detection
    always_comb begin
        rd_a    = ~drd_n;
        wr_a    = ~dwr_n;
        start   = (rd_a & ~rd_q1) | (wr_a & ~wr_q1);
        overlap = generic & host_busy & (rd_a | wr_a);
    end

    // Strobe history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q1 <= 1'b0;
            rd_q2 <= 1'b0;
            wr_q1 <= 1'b0;
        end else begin
            rd_q1 <= rd_a;
            rd_q2 <= rd_q1;
            wr_q1 <= wr_a;
        end
    end

    // Mark a transfer as lost once it overlaps a processor access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spoil  <= 1'b0;
            coll_q <= 1'b0;
        end else begin
            if (start)        spoil <= overlap;
            else if (overlap) spoil <= 1'b1;
            if (overlap)      coll_q <= 1'b1;
        end
    end

    // Write capture and pulse on strobe deassertion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbuf     <= '0;
            wdata_q  <= '0;
            dma_wr_q <= 1'b0;
        end else begin
            if (wr_a) wbuf <= data_i;
            dma_wr_q <= wr_q1 & ~wr_a & ~spoil;
            if (wr_q1 && !wr_a && !spoil) wdata_q <= wbuf;
        end
    end

    // Hold the DMA read word for the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf <= '0;
        end else if (dma_rd) begin
            rbuf <= dma_rdata;
        end
    end

    // Output assembly
    always_comb begin
        dma_rd     = rd_q1 & ~rd_q2 & ~spoil;
        dma_wr     = dma_wr_q;
        dma_wdata  = wdata_q;
        dbus_o     = rbuf;
        dbus_oe    = rd_q2 & rd_a & ~spoil;
        collision  = coll_q;
        dma_master = ~generic & master_req;
    end
endmodule

// File: rtl/cpu_bus_if.sv
`timescale 1ns/1ps
// Top of the configurable processor bus interface. Captures the topology
// strap during reset, synchronises all control pins, and combines the
// processor and DMA ports onto the shared data bus.
// Assumes: strap stable during reset; one clock domain for the core side.
module cpu_bus_if
    import cpu_bus_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_generic,
    input  logic          strobe_sel,
    input  logic          latch_sel,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          ds_n,
    input  logic          rw,
    input  logic          addr_sel,
    input  logic [AW-1:0] ad_i,
    output logic [AW-1:0] ad_o,
    output logic          ad_oe,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o,
    output logic          data_oe,
    input  logic          dma_rd_n,
    input  logic          dma_wr_n,
    input  logic          dma_master_req,
    output logic          dma_master,
    output logic [AW-1:0] reg_addr,
    output logic          reg_wr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_rd,
    input  logic [DW-1:0] reg_rdata,
    output logic          dma_wr,
    output logic [DW-1:0] dma_wdata,
    output logic          dma_rd,
    input  logic [DW-1:0] dma_rdata,
    output logic          collision
);
    localparam int CTL_W = $bits(ctl_t);

    logic          strap_q;
    bus_mode_e     mode;
    ctl_t          ctl_raw, ctl_s;
    logic          host_busy;
    logic [DW-1:0] host_dbus, dma_dbus;
    logic          host_dbus_oe, dma_dbus_oe;

    // Strap capture: follows the pin only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_generic;
    end

    // Effective decoding topology
    always_comb begin
        if (strap_q)        mode = MODE_GENERIC;
        else if (latch_sel) mode = MODE_SPLIT_SEL;
        else                mode = MODE_SPLIT_ALE;
    end

    // Group raw control pins
    always_comb begin
        ctl_raw = '{cs_n: cs_n, rd_n: rd_n, wr_n: wr_n, ds_n: ds_n,
                    rw: rw, sel: addr_sel, drd_n: dma_rd_n, dwr_n: dma_wr_n};
    end

    cpu_bus_sync #(
        .WIDTH   (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s)
    );

    cpu_bus_host_port #(
        .AW (AW),
        .DW (DW)
    ) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .strobe_sel (strobe_sel),
        .ctl        (ctl_s),
        .ad_i       (ad_i),
        .data_i     (data_i),
        .reg_rdata  (reg_rdata),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rd     (reg_rd),
        .busy       (host_busy),
        .ad_o       (ad_o),
        .ad_oe      (ad_oe),
        .dbus_o     (host_dbus),
        .dbus_oe    (host_dbus_oe)
    );

    cpu_bus_dma_port #(
        .DW (DW)
    ) u_dma (
        .clk        (clk),
        .rst_n      (rst_n),
        .generic    (strap_q),
        .drd_n      (ctl_s.drd_n),
        .dwr_n      (ctl_s.dwr_n),
        .host_busy  (host_busy),
        .master_req (dma_master_req),
        .data_i     (data_i),
        .dma_rdata  (dma_rdata),
        .dma_wr     (dma_wr),
        .dma_wdata  (dma_wdata),
        .dma_rd     (dma_rd),
        .dbus_o     (dma_dbus),
        .dbus_oe    (dma_dbus_oe),
        .collision  (collision),
        .dma_master (dma_master)
    );

    // Data bus arbitration: processor read wins over DMA read
    always_comb begin
        data_oe = host_dbus_oe | dma_dbus_oe;
        data_o  = host_dbus_oe ? host_dbus : dma_dbus;
    end
endmodule

// File: rtl/cpu_bus_if_chk.sv
`timescale 1ns/1ps
// Property checker for cpu_bus_if, attached by bind below.
// Assumes: observes top-level ports and the captured strap only.
module cpu_bus_if_chk (
    input logic clk,
    input logic rst_n,
    input logic strap_q,
    input logic reg_wr,
    input logic reg_rd,
    input logic dma_wr,
    input logic ad_oe,
    input logic collision,
    input logic dma_master
);
    // R1: captured strap never moves outside reset
    p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(strap_q));

    // R2: register write is a single-cycle pulse
    p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R4: register read is a single-cycle pulse
    p_rd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R6: multiplexed bus is never driven in the generic topology
    p_no_ad_generic_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strap_q |-> !ad_oe);

    // R8: DMA write is a single-cycle pulse
    p_dma_wr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr |=> !dma_wr);

    // R9: master operation only in the split topology
    p_master_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_master |-> !strap_q);

    // R10: collision flag is sticky until reset
    p_coll_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        collision |=> collision);

    // R11: no collision in the split topology
    p_no_coll_split_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_q |-> !collision);
endmodule

bind cpu_bus_if cpu_bus_if_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_q    (strap_q),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .dma_wr     (dma_wr),
    .ad_oe      (ad_oe),
    .collision  (collision),
    .dma_master (dma_master)
);

// File: tb/cpu_bus_if_bench.sv
`timescale 1ns/1ps
// Directed bench for cpu_bus_if: one task per scenario, each checking itself.
module cpu_bus_if_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_generic = 1'b1;
    logic        strobe_sel = 1'b1;
    logic        latch_sel = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
    logic        addr_sel = 1'b0;
    logic [7:0]  ad_i = '0;
    logic [7:0]  ad_o;
    logic        ad_oe;
    logic [15:0] data_i = '0;
    logic [15:0] data_o;
    logic        data_oe;
    logic        dma_rd_n = 1'b1, dma_wr_n = 1'b1, dma_master_req = 1'b0;
    logic        dma_master;
    logic [7:0]  reg_addr;
    logic        reg_wr, reg_rd, dma_wr, dma_rd, collision;
    logic [15:0] reg_wdata, reg_rdata, dma_wdata;
    logic [15:0] dma_rdata = 16'h0000;

    int n_chk = 0, n_fail = 0;
    int n_wr = 0, n_rd = 0, n_dwr = 0, n_drd = 0;
    logic [7:0]  last_waddr, last_raddr;
    logic [15:0] last_wdata, last_dwdata;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Register file stub: value is a fixed function of the address
    function automatic logic [15:0] stub(input logic [7:0] a);
        return {~a, a ^ 8'h5A};
    endfunction
    assign reg_rdata = stub(reg_addr);

    cpu_bus_if u_cpu_bus_if (
        .clk(clk), .rst_n(rst_n), .strap_generic(strap_generic),
        .strobe_sel(strobe_sel), .latch_sel(latch_sel), .cs_n(cs_n),
        .rd_n(rd_n), .wr_n(wr_n), .ds_n(ds_n), .rw(rw), .addr_sel(addr_sel),
        .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .data_i(data_i),
        .data_o(data_o), .data_oe(data_oe), .dma_rd_n(dma_rd_n),
        .dma_wr_n(dma_wr_n), .dma_master_req(dma_master_req),
        .dma_master(dma_master), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .dma_wr(dma_wr), .dma_wdata(dma_wdata), .dma_rd(dma_rd),
        .dma_rdata(dma_rdata), .collision(collision)
    );

    // Pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (reg_wr) begin n_wr++; last_waddr = reg_addr; last_wdata = reg_wdata; end
        if (reg_rd) begin n_rd++; last_raddr = reg_addr; end
        if (dma_wr) begin n_dwr++; last_dwdata = dma_wdata; end
        if (dma_rd) n_drd++;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0; strap_generic = strap;
        cs_n = 1; rd_n = 1; wr_n = 1; ds_n = 1; rw = 1; addr_sel = 0;
        dma_rd_n = 1; dma_wr_n = 1;
        cyc(4);
        rst_n = 1'b1;
        cyc(3);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d, input logic sel);
        ad_i = a; data_i = d; addr_sel = sel; cs_n = 0;
        cyc(1);
        if (strobe_sel) wr_n = 0; else begin rw = 0; ds_n = 0; end
        cyc(4);
        wr_n = 1; ds_n = 1;
        cyc(4);
        cs_n = 1; rw = 1; addr_sel = 0;
        cyc(2);
    endtask

    task automatic bus_read(input logic [7:0] a, input logic sel,
                            output logic [15:0] dv, output logic doe,
                            output logic [7:0] av, output logic aoe);
        ad_i = a; addr_sel = sel; cs_n = 0;
        cyc(1);
        if (strobe_sel) rd_n = 0; else begin rw = 1; ds_n = 0; end
        cyc(6);
        dv = data_o; doe = data_oe; av = ad_o; aoe = ad_oe;
        rd_n = 1; ds_n = 1;
        cyc(3);
        cs_n = 1; addr_sel = 0;
        cyc(3);
    endtask

    task automatic t_reset_state();
        strobe_sel = 1; latch_sel = 0; dma_master_req = 0;
        do_reset(1'b1);
        chk("R1 reset data_oe", 16'(data_oe), 16'd0);
        chk("R1 reset ad_oe", 16'(ad_oe), 16'd0);
        chk("R1 reset collision", 16'(collision), 16'd0);
        chk("R1 reset dma_master", 16'(dma_master), 16'd0);
        chk("R1 reset no write pulse", 16'(n_wr), 16'd0);
    endtask

    task automatic t_generic_write();
        int w0 = n_wr;
        strobe_sel = 1;
        bus_write(8'h3C, 16'hBEEF, 1'b0);
        chk("R2 one write pulse", 16'(n_wr - w0), 16'd1);
        chk("R2 write address", 16'(last_waddr), 16'h003C);
        chk("R2 write data", last_wdata, 16'hBEEF);
        bus_write(8'hC3, 16'h1234, 1'b0);
        chk("R2 second write data", last_wdata, 16'h1234);
        chk("R2 second write address", 16'(last_waddr), 16'h00C3);
    endtask

    task automatic t_strap_ignored();
        strap_generic = 1'b0;
        bus_write(8'h11, 16'hA5A5, 1'b0);
        chk("R1 strap change ignored, full word", last_wdata, 16'hA5A5);
        strap_generic = 1'b1;
    endtask

    task automatic t_generic_read();
        logic [15:0] dv; logic doe, aoe; logic [7:0] av;
        int r0 = n_rd;
        bus_read(8'h42, 1'b0, dv, doe, av, aoe);
        chk("R4 one read pulse", 16'(n_rd - r0), 16'd1);
        chk("R4 read address", 16'(last_raddr), 16'h0042);
        chk("R4 data bus value", dv, stub(8'h42));
        chk("R4 data bus driven", 16'(doe), 16'd1);
        chk("R4 mux bus idle", 16'(aoe), 16'd0);
    endtask

    task automatic t_ds_style();
        logic [15:0] dv; logic doe, aoe; logic [7:0] av;
        strobe_sel = 0;
        bus_write(8'h07, 16'h0F0F, 1'b0);
        chk("R3 direction-style write data", last_wdata, 16'h0F0F);
        chk("R3 direction-style write address", 16'(last_waddr), 16'h0007);
        bus_read(8'h08, 1'b0, dv, doe, av, aoe);
        chk("R3 direction-style read", dv, stub(8'h08));
        strobe_sel = 1;
    endtask

    task automatic t_cs_ignored();
        int w0 = n_wr, r0 = n_rd;
        logic doe_seen = 0;
        ad_i = 8'h55; data_i = 16'h7777;
        wr_n = 0; cyc(4); wr_n = 1; cyc(4);
        rd_n = 0;
        for (int i = 0; i < 6; i++) begin cyc(1); doe_seen |= data_oe; end
        rd_n = 1; cyc(4);
        chk("R5 no write without select", 16'(n_wr - w0), 16'd0);
        chk("R5 no read without select", 16'(n_rd - r0), 16'd0);
        chk("R5 no drive without select", 16'(doe_seen), 16'd0);
    endtask

    task automatic t_dma_generic();
        int d0 = n_dwr, r0 = n_drd;
        data_i = 16'h55AA;
        dma_wr_n = 0; cyc(4); dma_wr_n = 1; cyc(5);
        chk("R8 one dma write pulse", 16'(n_dwr - d0), 16'd1);
        chk("R8 dma write data", last_dwdata, 16'h55AA);
        dma_rdata = 16'h9876;
        dma_rd_n = 0; cyc(6);
        chk("R8 dma read value", data_o, 16'h9876);
        chk("R8 dma read drive", 16'(data_oe), 16'd1);
        dma_rd_n = 1; cyc(5);
        chk("R8 one dma read pulse", 16'(n_drd - r0), 16'd1);
        chk("R8 bus released", 16'(data_oe), 16'd0);
    endtask

    task automatic t_collision();
        int d0 = n_dwr, w0 = n_wr;
        data_i = 16'h1111;
        dma_wr_n = 0; cyc(2);
        bus_write(8'h20, 16'h1111, 1'b0);
        dma_wr_n = 1; cyc(5);
        chk("R10 overlapped dma dropped", 16'(n_dwr - d0), 16'd0);
        chk("R10 processor write done", 16'(n_wr - w0), 16'd1);
        chk("R10 collision set", 16'(collision), 16'd1);
        data_i = 16'h2222;
        dma_wr_n = 0; cyc(4); dma_wr_n = 1; cyc(5);
        chk("R10 clean dma after collision", 16'(n_dwr - d0), 16'd1);
        chk("R10 collision sticky", 16'(collision), 16'd1);
        dma_master_req = 1; cyc(1);
        chk("R9 no master in generic", 16'(dma_master), 16'd0);
        do_reset(1'b1);
        chk("R10 collision cleared by reset", 16'(collision), 16'd0);
    endtask

    task automatic t_split_ale();
        logic [15:0] dv; logic doe, aoe; logic [7:0] av;
        latch_sel = 0;
        do_reset(1'b0);
        chk("R9 master granted in split", 16'(dma_master), 16'd1);
        dma_master_req = 0; cyc(1);
        chk("R9 master follows request", 16'(dma_master), 16'd0);
        ad_i = 8'h66; addr_sel = 1; cyc(3); addr_sel = 0; cyc(3);
        bus_write(8'h9C, 16'hFFFF, 1'b0);
        chk("R6 latched address used", 16'(last_waddr), 16'h0066);
        chk("R6 byte write zero-extended", last_wdata, 16'h009C);
        bus_read(8'hEE, 1'b0, dv, doe, av, aoe);
        chk("R6 read low byte on mux bus", 16'(av), 16'(stub(8'h66) & 16'h00FF));
        chk("R6 mux bus driven", 16'(aoe), 16'd1);
        chk("R6 data bus not driven", 16'(doe), 16'd0);
    endtask

    task automatic t_split_sel();
        logic [15:0] dv; logic doe, aoe; logic [7:0] av;
        int w0, r0;
        latch_sel = 1;
        do_reset(1'b0);
        w0 = n_wr;
        bus_write(8'h31, 16'h0000, 1'b0);
        chk("R7 address phase writes nothing", 16'(n_wr - w0), 16'd0);
        bus_write(8'h77, 16'h0000, 1'b1);
        chk("R7 data phase write count", 16'(n_wr - w0), 16'd1);
        chk("R7 data phase address", 16'(last_waddr), 16'h0031);
        chk("R7 data phase data", last_wdata, 16'h0077);
        r0 = n_rd;
        bus_read(8'h00, 1'b0, dv, doe, av, aoe);
        chk("R7 address read-back", 16'(av), 16'h0031);
        chk("R7 no register read in address phase", 16'(n_rd - r0), 16'd0);
        bus_read(8'h00, 1'b1, dv, doe, av, aoe);
        chk("R7 data phase read", 16'(av), 16'(stub(8'h31) & 16'h00FF));
        chk("R7 data phase read count", 16'(n_rd - r0), 16'd1);
    endtask

    task automatic t_split_overlap();
        int d0 = n_dwr, w0 = n_wr;
        latch_sel = 0;
        ad_i = 8'h12; addr_sel = 1; cyc(3); addr_sel = 0; cyc(3);
        data_i = 16'hC0DE;
        dma_wr_n = 0; cyc(2);
        bus_write(8'h34, 16'hC0DE, 1'b0);
        dma_wr_n = 1; cyc(5);
        chk("R11 dma write completes", 16'(n_dwr - d0), 16'd1);
        chk("R11 dma data", last_dwdata, 16'hC0DE);
        chk("R11 processor write completes", 16'(n_wr - w0), 16'd1);
        chk("R11 no collision", 16'(collision), 16'd0);
    endtask

    initial begin
        t_reset_state();
        t_generic_write();
        t_strap_ignored();
        t_generic_read();
        t_ds_style();
        t_cs_ignored();
        t_dma_generic();
        t_collision();
        dma_master_req = 1;
        t_split_ale();
        t_split_sel();
        t_split_overlap();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule